// File: doc/BRIEF.md
# Interrupt Response Sequencer

This block takes over the processor's bus at an instruction boundary. It turns a pending non-maskable request, or an enabled maskable request, into an exact series of bus-cycle requests for the machine-cycle sequencer below it. It holds the program counter and stack pointer. It pushes the return address, loads the handler address and updates the two interrupt-enable flip-flops through a write strobe. It also runs the short start-up program after reset.

Each step is a single request to the machine-cycle sequencer. A request carries a bus kind, a length in half-cycles, an address and write data. The request stays valid until the sequencer returns a one-cycle done pulse, together with read data where the step reads. There are three maskable modes. Mode 1 jumps to a fixed handler. Mode 2 builds a table pointer from the vector-page register and the byte returned during the acknowledge, then loads the handler address from that table. Mode 0 does not run the supplied byte itself: it hands the byte back to the instruction decoder as an opcode.

Top module: `intresp_seq`

## Requirements
- R1: The request kind encoding is internal=0, fetch-open=1, fetch-wait=2, fetch-close=3, ack-open=4, ack-wait=5, ack-close=6, refresh=7, write=8, read=9. A request stays valid with stable fields until done.
- R2: After reset is released, the block issues exactly one internal request of 6 half-cycles. It then sets the PC to 0x0000 and the SP to 0xFFFF, and strobes both enable flags to 0.
- R3: A push writes the PC high byte to SP-1 and then the PC low byte to SP-2. Each write is 6 half-cycles. SP ends 2 lower than it started.
- R4: Mode 1 (mode input 1) issues ack-open 7, ack-wait 2, ack-close 3, refresh 4, then the push. It then sets the PC to 0x0038.
- R5: Mode 0 (mode input 0) issues ack-open 5, ack-wait 2 and ack-close 3. It then pulses the opcode hand-off with the byte captured at ack-close. PC and SP are left unchanged.
- R6: Mode 2 (mode input 2) issues the same acknowledge and refresh as mode 1, then the push. It then reads at {vector page, captured byte}, then at that address plus 1, and loads the PC with the second byte as the high half and the first as the low half.
- R7: A maskable request at a boundary is ignored while enable flag 1 is clear. No request is issued and the PC is unchanged.
- R8: The non-maskable response issues fetch-open 3, fetch-wait 2 and fetch-close 1 at the PC address, then refresh 6 and the push. It then sets the PC to 0x0066. The enable strobe copies flag 1 into flag 2 and clears flag 1.
- R9: Accepting a maskable request strobes both enable flags to 0.
- R10: A non-maskable request wins over a maskable one pending at the same boundary.
- R11: A non-maskable request is taken on a rising edge of its line. An edge is held until the next idle boundary, and a line held high gives only one response.
- R12: A boundary pulse that arrives while a sequence is running does not start a sequence.
- R13: When the halted input is set at acceptance, the pushed PC is the PC plus 1 and the halt-exit output pulses. A core load while idle sets the PC and SP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| at_boundary | input | 1 | Instruction boundary strobe |
| nmi_line | input | 1 | Non-maskable request line (edge taken) |
| int_line | input | 1 | Maskable request line (level) |
| int_mode | input | 2 | Maskable mode 0, 1 or 2 |
| iff1 | input | 1 | Enable flag 1 |
| iff2 | input | 1 | Enable flag 2 |
| vec_page | input | 8 | Vector page register |
| halted | input | 1 | Core is in the halted state |
| core_ld | input | 1 | Load PC and SP from the core |
| core_pc | input | 16 | PC value to load |
| core_sp | input | 16 | SP value to load |
| req_valid | output | 1 | Bus request valid |
| req_kind | output | 4 | Bus request kind |
| req_len | output | 4 | Request length in half-cycles |
| req_addr | output | 16 | Request address |
| req_wdata | output | 8 | Write data |
| req_done | input | 1 | Request completed |
| req_rdata | input | 8 | Read or acknowledge data |
| busy | output | 1 | A sequence is running |
| pc | output | 16 | Program counter |
| sp | output | 16 | Stack pointer |
| iff_we | output | 1 | Enable flag write strobe |
| iff1_new | output | 1 | New enable flag 1 |
| iff2_new | output | 1 | New enable flag 2 |
| halt_exit | output | 1 | Halt state released |
| m0_valid | output | 1 | Mode 0 opcode hand-off |
| m0_opcode | output | 8 | Opcode for the decoder |

## Verification
Each of the three maskable modes is run from a known PC and SP. The step lists differ in the opening length (5 against 7), in the presence of a push and in the trailing table reads, so a swapped mode or length shows up in the log. The non-maskable case is run with a maskable request also pending and with different enable-flag values, which separates the priority rule and the flag copy from the maskable clearing. Masked requests, a held request line, a boundary during a running sequence and a halted core are each checked to confirm that they produce no response or exactly one.

// File: rtl/intresp_pkg.sv
package intresp_pkg;

    typedef enum logic [3:0] {
        BK_INTERNAL    = 4'd0,
        BK_FETCH_OPEN  = 4'd1,
        BK_FETCH_WAIT  = 4'd2,
        BK_FETCH_CLOSE = 4'd3,
        BK_ACK_OPEN    = 4'd4,
        BK_ACK_WAIT    = 4'd5,
        BK_ACK_CLOSE   = 4'd6,
        BK_REFRESH     = 4'd7,
        BK_WRITE       = 4'd8,
        BK_READ        = 4'd9
    } bus_kind_e;

    typedef enum logic [2:0] {
        PG_RESET = 3'd0,
        PG_NMI   = 3'd1,
        PG_IM0   = 3'd2,
        PG_IM1   = 3'd3,
        PG_IM2   = 3'd4
    } prog_e;

    typedef enum logic [2:0] {
        AS_NONE = 3'd0,
        AS_PC   = 3'd1,
        AS_PUSH = 3'd2,
        AS_VEC  = 3'd3,
        AS_VEC1 = 3'd4
    } addr_src_e;

    typedef enum logic [1:0] {
        DS_NONE = 2'd0,
        DS_PCH  = 2'd1,
        DS_PCL  = 2'd2
    } data_src_e;

    typedef struct packed {
        bus_kind_e kind;
        logic [3:0] len;
        addr_src_e  asrc;
        data_src_e  dsrc;
        logic       last;
    } step_t;

    localparam int STEP_IDX_W = 3;

    function automatic step_t mk(bus_kind_e k, logic [3:0] l, addr_src_e a,
                                 data_src_e d, logic e);
        step_t s;
        s.kind = k;
        s.len  = l;
        s.asrc = a;
        s.dsrc = d;
        s.last = e;
        return s;
    endfunction

    // Steps shared by both acknowledge-with-push programs (modes 1 and 2).
    function automatic step_t ack_push_step(logic [STEP_IDX_W-1:0] i);
        case (i)
            3'd0:    return mk(BK_ACK_OPEN,  4'd7, AS_NONE, DS_NONE, 1'b0);
            3'd1:    return mk(BK_ACK_WAIT,  4'd2, AS_NONE, DS_NONE, 1'b0);
            3'd2:    return mk(BK_ACK_CLOSE, 4'd3, AS_NONE, DS_NONE, 1'b0);
            3'd3:    return mk(BK_REFRESH,   4'd4, AS_NONE, DS_NONE, 1'b0);
            3'd4:    return mk(BK_WRITE,     4'd6, AS_PUSH, DS_PCH,  1'b0);
            default: return mk(BK_WRITE,     4'd6, AS_PUSH, DS_PCL,  1'b0);
        endcase
    endfunction

    function automatic step_t step_of(prog_e p, logic [STEP_IDX_W-1:0] i);
        step_t s;
        s = mk(BK_INTERNAL, 4'd0, AS_NONE, DS_NONE, 1'b1);
        case (p)
            PG_RESET: s = mk(BK_INTERNAL, 4'd6, AS_NONE, DS_NONE, 1'b1);
            PG_NMI: begin
                case (i)
                    3'd0: s = mk(BK_FETCH_OPEN,  4'd3, AS_PC,   DS_NONE, 1'b0);
                    3'd1: s = mk(BK_FETCH_WAIT,  4'd2, AS_PC,   DS_NONE, 1'b0);
                    3'd2: s = mk(BK_FETCH_CLOSE, 4'd1, AS_PC,   DS_NONE, 1'b0);
                    3'd3: s = mk(BK_REFRESH,     4'd6, AS_NONE, DS_NONE, 1'b0);
                    3'd4: s = mk(BK_WRITE,       4'd6, AS_PUSH, DS_PCH,  1'b0);
                    default: s = mk(BK_WRITE,    4'd6, AS_PUSH, DS_PCL,  1'b1);
                endcase
            end
            PG_IM0: begin
                case (i)
                    3'd0: s = mk(BK_ACK_OPEN,  4'd5, AS_NONE, DS_NONE, 1'b0);
                    3'd1: s = mk(BK_ACK_WAIT,  4'd2, AS_NONE, DS_NONE, 1'b0);
                    default: s = mk(BK_ACK_CLOSE, 4'd3, AS_NONE, DS_NONE, 1'b1);
                endcase
            end
            PG_IM1: begin
                s = ack_push_step(i);
                if (i >= 3'd5) s.last = 1'b1;
            end
            PG_IM2: begin
                case (i)
                    3'd6: s = mk(BK_READ, 4'd6, AS_VEC,  DS_NONE, 1'b0);
                    3'd7: s = mk(BK_READ, 4'd6, AS_VEC1, DS_NONE, 1'b1);
                    default: s = ack_push_step(i);
                endcase
            end
            default: s = mk(BK_INTERNAL, 4'd0, AS_NONE, DS_NONE, 1'b1);
        endcase
        return s;
    endfunction

endpackage

// File: rtl/intresp_nmi_latch.sv
module intresp_nmi_latch (
    input  logic clk,
    input  logic rst,
    input  logic nmi_line,
    input  logic clr,
    output logic pend
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            pend   <= 1'b0;
        end else begin
            prev_q <= nmi_line;
            // A fresh edge outranks a clear in the same cycle.
            if (nmi_line && !prev_q) pend <= 1'b1;
            else if (clr)            pend <= 1'b0;
        end
    end
endmodule

// File: rtl/intresp_arbiter.sv
module intresp_arbiter
    import intresp_pkg::*;
(
    input  logic       idle,
    input  logic       at_boundary,
    input  logic       nmi_pend,
    input  logic       int_line,
    input  logic [1:0] int_mode,
    input  logic       iff1,
    output logic       take,
    output prog_e      take_prog,
    output logic       nmi_clr,
    output logic       flag1_new,
    output logic       flag2_new
);
    logic window;
    logic want_int;

    assign window   = idle && at_boundary;
    assign want_int = int_line && iff1;

    always_comb begin
        take      = 1'b0;
        take_prog = PG_IM1;
        nmi_clr   = 1'b0;
        flag1_new = 1'b0;
        flag2_new = 1'b0;
        if (window && nmi_pend) begin
            take      = 1'b1;
            take_prog = PG_NMI;
            nmi_clr   = 1'b1;
            flag2_new = iff1;
        end else if (window && want_int) begin
            take = 1'b1;
            unique case (int_mode)
                2'd0:    take_prog = PG_IM0;
                2'd1:    take_prog = PG_IM1;
                default: take_prog = PG_IM2;
            endcase
        end
    end
endmodule

// File: rtl/intresp_regs.sv
module intresp_regs #(
    parameter int          ADDR_W   = 16,
    parameter logic [15:0] SP_RESET = 16'hFFFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld,
    input  logic [ADDR_W-1:0] ld_pc,
    input  logic [ADDR_W-1:0] ld_sp,
    input  logic              bump,
    input  logic              dec_sp,
    input  logic              pc_wr,
    input  logic [ADDR_W-1:0] pc_wval,
    output logic [ADDR_W-1:0] pc_q,
    output logic [ADDR_W-1:0] sp_q
);
    logic [ADDR_W-1:0] pc_base;
    logic [ADDR_W-1:0] bump_ext;

    assign pc_base  = ld ? ld_pc : pc_q;
    assign bump_ext = {{(ADDR_W-1){1'b0}}, bump};

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
            sp_q <= SP_RESET[ADDR_W-1:0];
        end else begin
            if (pc_wr) pc_q <= pc_wval;
            else       pc_q <= pc_base + bump_ext;
            if (dec_sp)  sp_q <= sp_q - 1'b1;
            else if (ld) sp_q <= ld_sp;
        end
    end
endmodule

// File: rtl/intresp_seq.sv
module intresp_seq
    import intresp_pkg::*;
#(
    parameter int          DATA_W     = 8,
    parameter logic [15:0] NMI_TARGET = 16'h0066,
    parameter logic [15:0] IM1_TARGET = 16'h0038,
    parameter logic [15:0] RESET_PC   = 16'h0000,
    parameter logic [15:0] SP_RESET   = 16'hFFFF
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  at_boundary,
    input  logic                  nmi_line,
    input  logic                  int_line,
    input  logic [1:0]            int_mode,
    input  logic                  iff1,
    input  logic                  iff2,
    input  logic [DATA_W-1:0]     vec_page,
    input  logic                  halted,
    input  logic                  core_ld,
    input  logic [2*DATA_W-1:0]   core_pc,
    input  logic [2*DATA_W-1:0]   core_sp,
    output logic                  req_valid,
    output logic [3:0]            req_kind,
    output logic [3:0]            req_len,
    output logic [2*DATA_W-1:0]   req_addr,
    output logic [DATA_W-1:0]     req_wdata,
    input  logic                  req_done,
    input  logic [DATA_W-1:0]     req_rdata,
    output logic                  busy,
    output logic [2*DATA_W-1:0]   pc,
    output logic [2*DATA_W-1:0]   sp,
    output logic                  iff_we,
    output logic                  iff1_new,
    output logic                  iff2_new,
    output logic                  halt_exit,
    output logic                  m0_valid,
    output logic [DATA_W-1:0]     m0_opcode
);
    localparam int ADDR_W = 2 * DATA_W;

    logic                  active_q;
    prog_e                 prog_q;
    logic [STEP_IDX_W-1:0] idx_q;
    logic [DATA_W-1:0]     vec_q;
    logic [DATA_W-1:0]     lo_q;

    step_t cur;
    logic  step_done;
    logic  finish;

    logic  nmi_pend_w;
    logic  take;
    prog_e take_prog;
    logic  nmi_clr;
    logic  flag1_w;
    logic  flag2_w;

    logic              pc_wr;
    logic [ADDR_W-1:0] pc_wval;
    logic [ADDR_W-1:0] vec_addr;

    // iff2 is part of the core's flag state; only iff1 steers acceptance.
    logic unused_iff2;
    assign unused_iff2 = iff2;

    intresp_nmi_latch u_nmi (
        .clk      (clk),
        .rst      (rst),
        .nmi_line (nmi_line),
        .clr      (nmi_clr),
        .pend     (nmi_pend_w)
    );

    intresp_arbiter u_arb (
        .idle        (!active_q && !rst),
        .at_boundary (at_boundary),
        .nmi_pend    (nmi_pend_w),
        .int_line    (int_line),
        .int_mode    (int_mode),
        .iff1        (iff1),
        .take        (take),
        .take_prog   (take_prog),
        .nmi_clr     (nmi_clr),
        .flag1_new   (flag1_w),
        .flag2_new   (flag2_w)
    );

    assign cur       = step_of(prog_q, idx_q);
    assign step_done = active_q && !rst && req_done;
    assign finish    = step_done && cur.last;
    assign vec_addr  = {vec_page, vec_q};

    always_comb begin
        unique case (prog_q)
            PG_RESET: pc_wval = RESET_PC[ADDR_W-1:0];
            PG_NMI:   pc_wval = NMI_TARGET[ADDR_W-1:0];
            PG_IM1:   pc_wval = IM1_TARGET[ADDR_W-1:0];
            default:  pc_wval = {req_rdata, lo_q};
        endcase
    end
    assign pc_wr = finish && (prog_q != PG_IM0);

    intresp_regs #(
        .ADDR_W   (ADDR_W),
        .SP_RESET (SP_RESET)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .ld      (core_ld && !active_q),
        .ld_pc   (core_pc),
        .ld_sp   (core_sp),
        .bump    (take && halted),
        .dec_sp  (step_done && (cur.kind == BK_WRITE)),
        .pc_wr   (pc_wr),
        .pc_wval (pc_wval),
        .pc_q    (pc),
        .sp_q    (sp)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b1;
            prog_q   <= PG_RESET;
            idx_q    <= '0;
            vec_q    <= '0;
            lo_q     <= '0;
        end else if (take) begin
            active_q <= 1'b1;
            prog_q   <= take_prog;
            idx_q    <= '0;
        end else if (step_done) begin
            if (cur.kind == BK_ACK_CLOSE) vec_q <= req_rdata;
            if (cur.kind == BK_READ)      lo_q  <= req_rdata;
            if (cur.last) active_q <= 1'b0;
            else          idx_q    <= idx_q + 1'b1;
        end
    end

    always_comb begin
        unique case (cur.asrc)
            AS_PC:   req_addr = pc;
            AS_PUSH: req_addr = sp - 1'b1;
            AS_VEC:  req_addr = vec_addr;
            AS_VEC1: req_addr = vec_addr + 1'b1;
            default: req_addr = '0;
        endcase
        unique case (cur.dsrc)
            DS_PCH:  req_wdata = pc[ADDR_W-1:DATA_W];
            DS_PCL:  req_wdata = pc[DATA_W-1:0];
            default: req_wdata = '0;
        endcase
    end

    assign req_valid = active_q && !rst;
    assign req_kind  = cur.kind;
    assign req_len   = cur.len;
    assign busy      = active_q;

    assign iff_we    = take || (finish && prog_q == PG_RESET);
    assign iff1_new  = take ? flag1_w : 1'b0;
    assign iff2_new  = take ? flag2_w : 1'b0;
    assign halt_exit = take && halted;
    assign m0_valid  = finish && (prog_q == PG_IM0);
    assign m0_opcode = req_rdata;

endmodule

// File: rtl/intresp_seq_chk.sv
module intresp_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        at_boundary,
    input logic        int_line,
    input logic        iff1,
    input logic        nmi_pend,
    input logic        req_valid,
    input logic        req_done,
    input logic [3:0]  req_kind,
    input logic [15:0] req_addr,
    input logic [15:0] sp,
    input logic        busy,
    input logic        iff_we,
    input logic        iff1_new,
    input logic        halt_exit
);
    // R1: request fields hold until the sequencer completes the step
    a_r1_req_hold: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_done |=> req_valid && $stable(req_kind) && $stable(req_addr));

    // R3: every write goes one below the current stack pointer
    a_r3_push_addr: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_kind == 4'd8 |-> req_addr == sp - 16'd1);

    // R7: masked request with nothing else pending never starts a sequence
    a_r7_masked_idle: assert property (@(posedge clk) disable iff (rst)
        !busy && at_boundary && !nmi_pend && !iff1 |=> !busy);

    // R9: every enable-flag strobe leaves flag 1 clear
    a_r9_flag1_clear: assert property (@(posedge clk) disable iff (rst)
        iff_we |-> !iff1_new);

    // R12: no acceptance while a sequence is running
    a_r12_busy_no_take: assert property (@(posedge clk) disable iff (rst)
        busy && at_boundary && !req_done |-> !iff_we);

    // R13: halt release only comes with an acceptance
    a_r13_halt_with_take: assert property (@(posedge clk) disable iff (rst)
        halt_exit |-> iff_we && !busy);

    // R11: a pending edge is cleared only by starting a sequence
    a_r11_pend_kept: assert property (@(posedge clk) disable iff (rst)
        $fell(nmi_pend) |-> busy);

    logic unused_int;
    assign unused_int = int_line;
endmodule

bind intresp_seq intresp_seq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .at_boundary (at_boundary),
    .int_line    (int_line),
    .iff1        (iff1),
    .nmi_pend    (nmi_pend_w),
    .req_valid   (req_valid),
    .req_done    (req_done),
    .req_kind    (req_kind),
    .req_addr    (req_addr),
    .sp          (sp),
    .busy        (busy),
    .iff_we      (iff_we),
    .iff1_new    (iff1_new),
    .halt_exit   (halt_exit)
);

// File: tb/intresp_seq_tb.sv
module intresp_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        at_boundary = 1'b0;
    logic        nmi_line = 1'b0;
    logic        int_line = 1'b0;
    logic [1:0]  int_mode = 2'd1;
    logic        iff1 = 1'b0;
    logic        iff2 = 1'b0;
    logic [7:0]  vec_page = 8'h00;
    logic        halted = 1'b0;
    logic        core_ld = 1'b0;
    logic [15:0] core_pc = '0;
    logic [15:0] core_sp = '0;
    logic        req_valid;
    logic [3:0]  req_kind;
    logic [3:0]  req_len;
    logic [15:0] req_addr;
    logic [7:0]  req_wdata;
    logic        req_done = 1'b0;
    logic [7:0]  req_rdata = '0;
    logic        busy;
    logic [15:0] pc;
    logic [15:0] sp;
    logic        iff_we;
    logic        iff1_new;
    logic        iff2_new;
    logic        halt_exit;
    logic        m0_valid;
    logic [7:0]  m0_opcode;

    always #2.5 clk = ~clk;

    intresp_seq dut_i (.*);

    int n_tests = 0;
    int n_fail  = 0;

    // Sequencer model with a short fixed latency and a request log.
    logic [7:0]  mem [256];
    logic [7:0]  ack_byte = 8'h00;
    logic [3:0]  lg_kind [16];
    logic [3:0]  lg_len  [16];
    logic [15:0] lg_addr [16];
    logic [7:0]  lg_data [16];
    int          log_n = 0;
    logic        clr_caps = 1'b0;
    int          lat = 0;

    always @(posedge clk) begin
        if (clr_caps) log_n <= 0;
        if (rst || req_done || !req_valid) begin
            req_done <= 1'b0;
            lat <= 0;
        end else if (lat == 2) begin
            req_done <= 1'b1;
            lat <= 0;
            if (req_kind >= 4'd4 && req_kind <= 4'd6) req_rdata <= ack_byte;
            else                                      req_rdata <= mem[req_addr[7:0]];
            if (req_kind == 4'd8) mem[req_addr[7:0]] <= req_wdata;
            if (!clr_caps && log_n < 16) begin
                lg_kind[log_n] <= req_kind;
                lg_len[log_n]  <= req_len;
                lg_addr[log_n] <= req_addr;
                lg_data[log_n] <= req_wdata;
                log_n <= log_n + 1;
            end
        end else begin
            lat <= lat + 1;
        end
    end

    logic       we_seen, we1, we2, hx_seen, m0_seen;
    logic [7:0] m0_cap;
    always @(posedge clk) begin
        if (clr_caps) begin
            we_seen <= 1'b0; we1 <= 1'b1; we2 <= 1'b1;
            hx_seen <= 1'b0; m0_seen <= 1'b0; m0_cap <= '0;
        end else begin
            if (iff_we)    begin we_seen <= 1'b1; we1 <= iff1_new; we2 <= iff2_new; end
            if (halt_exit) hx_seen <= 1'b1;
            if (m0_valid)  begin m0_seen <= 1'b1; m0_cap <= m0_opcode; end
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic clear_caps();
        @(negedge clk) clr_caps = 1'b1;
        @(negedge clk) clr_caps = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (!busy) break;
        end
    endtask

    task automatic boundary();
        @(negedge clk) at_boundary = 1'b1;
        @(negedge clk) at_boundary = 1'b0;
        wait_idle();
    endtask

    task automatic load(input logic [15:0] p, input logic [15:0] s);
        @(negedge clk) begin core_ld = 1'b1; core_pc = p; core_sp = s; end
        @(negedge clk) core_ld = 1'b0;
    endtask

    task automatic chk_step(input string req, input int i, input logic [3:0] k,
                            input logic [3:0] l);
        chk(req, $sformatf("step %0d kind", i), {28'd0, lg_kind[i]}, {28'd0, k});
        chk(req, $sformatf("step %0d len", i),  {28'd0, lg_len[i]},  {28'd0, l});
    endtask

    task automatic chk_wr(input string req, input int i, input logic [15:0] a,
                          input logic [7:0] d);
        chk_step(req, i, 4'd8, 4'd6);
        chk(req, $sformatf("step %0d addr", i), {16'd0, lg_addr[i]}, {16'd0, a});
        chk(req, $sformatf("step %0d data", i), {24'd0, lg_data[i]}, {24'd0, d});
    endtask

    task automatic t_reset();
        clr_caps = 1'b1;
        repeat (3) @(negedge clk);
        clr_caps = 1'b0;
        rst = 1'b0;
        wait_idle();
        repeat (2) @(negedge clk);
        chk("R2", "log count", log_n, 1);
        chk_step("R2", 0, 4'd0, 4'd6);
        chk("R2", "pc", {16'd0, pc}, 32'h0000);
        chk("R2", "sp", {16'd0, sp}, 32'hFFFF);
        chk("R2", "flag strobe", {31'd0, we_seen}, 1);
        chk("R2", "flags", {30'd0, we1, we2}, 0);
    endtask

    task automatic t_load();
        load(16'h1234, 16'h8000);
        chk("R13", "loaded pc", {16'd0, pc}, 32'h1234);
        chk("R13", "loaded sp", {16'd0, sp}, 32'h8000);
    endtask

    task automatic t_masked();
        clear_caps();
        int_line = 1'b1; int_mode = 2'd1; iff1 = 1'b0;
        boundary();
        repeat (8) @(negedge clk);
        chk("R7", "log count", log_n, 0);
        chk("R7", "busy", {31'd0, busy}, 0);
        chk("R7", "pc", {16'd0, pc}, 32'h1234);
        int_line = 1'b0;
    endtask

    task automatic t_mode1();
        load(16'h1234, 16'h8000);
        clear_caps();
        int_line = 1'b1; int_mode = 2'd1; iff1 = 1'b1; iff2 = 1'b1;
        boundary();
        int_line = 1'b0;
        chk("R4", "log count", log_n, 6);
        chk_step("R4", 0, 4'd4, 4'd7);
        chk_step("R4", 1, 4'd5, 4'd2);
        chk_step("R4", 2, 4'd6, 4'd3);
        chk_step("R4", 3, 4'd7, 4'd4);
        chk_wr("R3", 4, 16'h7FFF, 8'h12);
        chk_wr("R3", 5, 16'h7FFE, 8'h34);
        chk("R4", "pc", {16'd0, pc}, 32'h0038);
        chk("R3", "sp", {16'd0, sp}, 32'h7FFE);
        chk("R9", "flags", {29'd0, we_seen, we1, we2}, 32'h4);
    endtask

    task automatic t_mode0();
        load(16'h1234, 16'h8000);
        clear_caps();
        ack_byte = 8'hC7;
        int_line = 1'b1; int_mode = 2'd0; iff1 = 1'b1;
        boundary();
        int_line = 1'b0;
        chk("R5", "log count", log_n, 3);
        chk_step("R5", 0, 4'd4, 4'd5);
        chk_step("R5", 1, 4'd5, 4'd2);
        chk_step("R5", 2, 4'd6, 4'd3);
        chk("R5", "handoff", {31'd0, m0_seen}, 1);
        chk("R5", "opcode", {24'd0, m0_cap}, 32'hC7);
        chk("R5", "pc", {16'd0, pc}, 32'h1234);
        chk("R5", "sp", {16'd0, sp}, 32'h8000);
    endtask

    task automatic t_mode2();
        load(16'h1234, 16'h8000);
        clear_caps();
        ack_byte = 8'h40; vec_page = 8'h12;
        mem[8'h40] = 8'h78; mem[8'h41] = 8'h56;
        int_line = 1'b1; int_mode = 2'd2; iff1 = 1'b1;
        boundary();
        int_line = 1'b0;
        chk("R6", "log count", log_n, 8);
        chk_step("R6", 0, 4'd4, 4'd7);
        chk_step("R6", 3, 4'd7, 4'd4);
        chk_wr("R6", 4, 16'h7FFF, 8'h12);
        chk_wr("R6", 5, 16'h7FFE, 8'h34);
        chk_step("R6", 6, 4'd9, 4'd6);
        chk("R6", "table low addr", {16'd0, lg_addr[6]}, 32'h1240);
        chk_step("R6", 7, 4'd9, 4'd6);
        chk("R6", "table high addr", {16'd0, lg_addr[7]}, 32'h1241);
        chk("R6", "pc", {16'd0, pc}, 32'h5678);
        chk("R6", "sp", {16'd0, sp}, 32'h7FFE);
    endtask

    task automatic t_nmi();
        load(16'h2000, 16'h9000);
        clear_caps();
        int_line = 1'b1; int_mode = 2'd1; iff1 = 1'b1; iff2 = 1'b0;
        @(negedge clk) nmi_line = 1'b1;
        boundary();
        int_line = 1'b0;
        chk("R10", "log count", log_n, 6);
        chk_step("R8", 0, 4'd1, 4'd3);
        chk_step("R8", 1, 4'd2, 4'd2);
        chk_step("R8", 2, 4'd3, 4'd1);
        chk("R8", "fetch addr", {16'd0, lg_addr[0]}, 32'h2000);
        chk_step("R8", 3, 4'd7, 4'd6);
        chk_wr("R8", 4, 16'h8FFF, 8'h20);
        chk_wr("R8", 5, 16'h8FFE, 8'h00);
        chk("R8", "pc", {16'd0, pc}, 32'h0066);
        chk("R8", "flag copy", {29'd0, we_seen, we1, we2}, 32'h5);
        // Line still high: a second boundary gives no response.
        clear_caps();
        boundary();
        repeat (6) @(negedge clk);
        chk("R11", "held line log", log_n, 0);
        nmi_line = 1'b0;
    endtask

    task automatic t_halt();
        load(16'h3000, 16'h8000);
        clear_caps();
        halted = 1'b1;
        int_line = 1'b1; int_mode = 2'd1; iff1 = 1'b1;
        boundary();
        int_line = 1'b0; halted = 1'b0;
        chk("R13", "halt exit", {31'd0, hx_seen}, 1);
        chk_wr("R13", 4, 16'h7FFF, 8'h30);
        chk_wr("R13", 5, 16'h7FFE, 8'h01);
    endtask

    task automatic t_busy_boundary();
        load(16'h1234, 16'h8000);
        clear_caps();
        int_line = 1'b1; int_mode = 2'd1; iff1 = 1'b1;
        @(negedge clk) at_boundary = 1'b1;
        @(negedge clk) begin at_boundary = 1'b0; int_line = 1'b0; end
        repeat (3) @(negedge clk);
        nmi_line = 1'b1;
        @(negedge clk) at_boundary = 1'b1;
        @(negedge clk) at_boundary = 1'b0;
        wait_idle();
        repeat (6) @(negedge clk);
        chk("R12", "no restart", {31'd0, busy}, 0);
        chk("R12", "log count", log_n, 6);
        chk("R12", "pc", {16'd0, pc}, 32'h0038);
        clear_caps();
        boundary();
        chk("R11", "held edge served", log_n, 6);
        chk_step("R11", 0, 4'd1, 4'd3);
        chk("R11", "pc", {16'd0, pc}, 32'h0066);
        nmi_line = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (4) @(negedge clk);
        t_reset();
        t_load();
        t_masked();
        t_mode1();
        t_mode0();
        t_mode2();
        t_nmi();
        t_halt();
        t_busy_boundary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule